// File: doc/BRIEF.md
# ADC Step Sequencer with Averaging

This block drives an external analog-to-digital converter through a programmable list of up to eight conversion steps. Each step holds its own input channel, a settling delay applied before conversion, a sample-hold period, and a power-of-two averaging count. The sequencer presents the step's channel and waits out the settling delay. It then raises start-of-conversion for the sample period and waits for the converter's done pulse. It repeats the sample-and-convert part until the averaging count is reached, and emits the truncated mean tagged with the step index.

Software-side settings arrive through a simple write port that addresses one step at a time. Out-of-range requests are clamped when they are written. The level-sensitive enable starts a pass at step 0. A mode input selects between a single pass and an endless loop over steps 0 to the configured last step. Dropping the enable lets the step in progress finish and report before the sequencer goes idle.

Top module: `adc_step_seq`

## Requirements
- R1: While idle, a high `en_i` starts a pass at step 0. Steps run in ascending index order up to `last_step_i`. `ch_o` carries the step's configured channel from the start of the step and stays stable while `soc_o` is high.
- R2: `res_valid_o` is high in cycle T. If a next step follows, `soc_o` first rises in cycle T + open + 1, where open is that step's stored open delay. An open delay of 0 gives a rise in cycle T + 1.
- R3: Each `soc_o` pulse lasts exactly the stored sample delay in cycles. A stored sample delay of 0 gives a one-cycle pulse.
- R4: A step issues exactly N conversions. A requested count of 16 or more gives N = 16; otherwise N is the largest power of two not above the request, and a request of 0 or 1 gives N = 1. N is stored as its base-2 logarithm.
- R5: `res_data_o` equals the sum of the step's N converter words divided by N and truncated.
- R6: An open-delay request above 2^OPEN_W − 1 is stored as 2^OPEN_W − 1. A sample-delay request above 2^SAMP_W − 1 is stored as 2^SAMP_W − 1.
- R7: `res_valid_o` is a one-cycle strobe. In the same cycle, `res_step_o` gives the index of the step that produced the result.
- R8: After reset, `soc_o`, `res_valid_o` and `ch_o` are 0. Every step defaults to channel equal to its index, open delay 0, sample delay 0 and 16-sample averaging.
- R9: With `cont_i` low, one pass ends after the last step. No further `soc_o` occurs while `en_i` stays high, and a low-then-high `en_i` starts a new pass at step 0.
- R10: With `cont_i` high, the step after `last_step_i` is step 0.
- R11: If `en_i` is low when a step's final conversion completes, that step's result is still emitted and no further `soc_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (converter clock domain) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable, level sensitive |
| cont_i | input | 1 | 1: loop continuously, 0: single pass |
| last_step_i | input | STEP_W | Index of the final step in a pass |
| cfg_we_i | input | 1 | Write strobe for one step's settings |
| cfg_step_i | input | STEP_W | Step addressed by the write |
| cfg_chan_i | input | CHAN_W | Channel select for the step |
| cfg_open_i | input | OPEN_W+2 | Requested open delay (clamped) |
| cfg_samp_i | input | SAMP_W+2 | Requested sample delay (clamped) |
| cfg_avg_i | input | 6 | Requested sample count (clamped, rounded down to a power of two) |
| ch_o | output | CHAN_W | Channel select to the converter |
| soc_o | output | 1 | Start-of-conversion / sample-hold |
| adc_done_i | input | 1 | One-cycle conversion-complete pulse |
| adc_data_i | input | DATA_W | Conversion word, valid with done |
| res_valid_o | output | 1 | Averaged result strobe |
| res_data_o | output | DATA_W | Averaged result |
| res_step_o | output | STEP_W | Step index of the result |

## Verification
The completion of a step's last conversion is one event. On that edge the sequencer emits the result and chooses what comes next: advance, wrap to step 0, hold, or stop. In continuous mode the bench clears the enable while the wrapped-around step 0 has its conversion outstanding, so the loop decision and the stop request meet on that one done edge. It is judged by requiring the pending result with index 0 and then silence on start-of-conversion. It also checks that the step-index sequence up to that point alternates 0, 1, 0, 1, 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_APPLY, S_OPEN, S_SOC, S_WAIT, S_HOLD
  } seq_state_e;

  localparam int AVG_CODE_W = 3;
  localparam int AVG_REQ_W  = 6;
  localparam logic [AVG_CODE_W-1:0] AVG_CODE_MAX = 3'd4;

  // requested count -> log2 code, clamped to 16 samples, rounded down
  function automatic logic [AVG_CODE_W-1:0] avg_code(input logic [AVG_REQ_W-1:0] req);
    if (req >= 6'd16)     return 3'd4;
    else if (req >= 6'd8) return 3'd3;
    else if (req >= 6'd4) return 3'd2;
    else if (req >= 6'd2) return 3'd1;
    else                  return 3'd0;
  endfunction
endpackage

// File: rtl/adc_step_cfg.sv
module adc_step_cfg
  import adc_seq_pkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int STEP_W    = 3,
  parameter int CHAN_W    = 4,
  parameter int OPEN_W    = 18,
  parameter int SAMP_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [STEP_W-1:0]     idx_i,
  input  logic [CHAN_W-1:0]     chan_i,
  input  logic [OPEN_W+1:0]     open_i,
  input  logic [SAMP_W+1:0]     samp_i,
  input  logic [AVG_REQ_W-1:0]  avg_i,
  output logic [CHAN_W-1:0]     chan_o [NUM_STEPS],
  output logic [OPEN_W-1:0]     open_o [NUM_STEPS],
  output logic [SAMP_W-1:0]     samp_o [NUM_STEPS],
  output logic [AVG_CODE_W-1:0] code_o [NUM_STEPS]
);
  logic [OPEN_W-1:0]     open_sat;
  logic [SAMP_W-1:0]     samp_sat;
  logic [AVG_CODE_W-1:0] code_sat;

  assign open_sat = (|open_i[OPEN_W+1:OPEN_W]) ? '1 : open_i[OPEN_W-1:0];
  assign samp_sat = (|samp_i[SAMP_W+1:SAMP_W]) ? '1 : samp_i[SAMP_W-1:0];
  assign code_sat = avg_code(avg_i);

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chan_o[g] <= CHAN_W'(g);
        open_o[g] <= '0;
        samp_o[g] <= '0;
        code_o[g] <= AVG_CODE_MAX;
      end else if (we_i && idx_i == STEP_W'(g)) begin
        chan_o[g] <= chan_i;
        open_o[g] <= open_sat;
        samp_o[g] <= samp_sat;
        code_o[g] <= code_sat;
      end
    end

    p_avg_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == STEP_W'(g) && avg_i >= 6'd16) |=> (code_o[g] == AVG_CODE_MAX));

    p_open_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == STEP_W'(g) && (|open_i[OPEN_W+1:OPEN_W])) |=> (&open_o[g]));
  end
endmodule

// File: rtl/adc_step_fsm.sv
module adc_step_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int STEP_W    = 3,
  parameter int CHAN_W    = 4,
  parameter int OPEN_W    = 18,
  parameter int SAMP_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  cont_i,
  input  logic [STEP_W-1:0]     last_i,
  input  logic [CHAN_W-1:0]     chan_a_i [NUM_STEPS],
  input  logic [OPEN_W-1:0]     open_a_i [NUM_STEPS],
  input  logic [SAMP_W-1:0]     samp_a_i [NUM_STEPS],
  input  logic [AVG_CODE_W-1:0] code_a_i [NUM_STEPS],
  input  logic                  done_i,
  output logic [CHAN_W-1:0]     ch_o,
  output logic                  soc_o,
  output logic                  add_o,
  output logic                  fire_o,
  output logic [AVG_CODE_W-1:0] code_o,
  output logic [STEP_W-1:0]     step_o
);
  localparam int CNT_W = (OPEN_W > SAMP_W) ? OPEN_W : SAMP_W;

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q, lst, nxt;
  logic [CNT_W-1:0]  cnt_q, samp_ld;
  logic [4:0]        smp_q, smp_need;
  logic              last_smp;

  assign lst      = (32'(last_i) > NUM_STEPS - 1) ? STEP_W'(NUM_STEPS - 1) : last_i;
  assign nxt      = (step_q == lst) ? '0 : STEP_W'(step_q + 1'b1);
  assign samp_ld  = (samp_a_i[step_q] == '0) ? CNT_W'(1) : CNT_W'(samp_a_i[step_q]);
  assign code_o   = code_a_i[step_q];
  assign smp_need = (5'd1 << code_o) - 5'd1;
  assign last_smp = (smp_q == smp_need);

  assign soc_o  = (state_q == S_SOC);
  assign add_o  = (state_q == S_WAIT) && done_i;
  assign fire_o = add_o && last_smp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      ch_o    <= '0;
      cnt_q   <= '0;
      smp_q   <= '0;
      step_o  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (en_i) begin
          state_q <= S_APPLY;
          step_q  <= '0;
          ch_o    <= chan_a_i[0];
          smp_q   <= '0;
        end
        S_APPLY: begin
          if (open_a_i[step_q] == '0) begin
            state_q <= S_SOC;
            cnt_q   <= samp_ld;
          end else begin
            state_q <= S_OPEN;
            cnt_q   <= CNT_W'(open_a_i[step_q]);
          end
        end
        S_OPEN: begin
          if (cnt_q <= CNT_W'(1)) begin
            state_q <= S_SOC;
            cnt_q   <= samp_ld;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_SOC: begin
          if (cnt_q <= CNT_W'(1)) state_q <= S_WAIT;
          else cnt_q <= cnt_q - 1'b1;
        end
        S_WAIT: if (done_i) begin
          if (last_smp) begin
            smp_q  <= '0;
            step_o <= step_q;
            if (!en_i) state_q <= S_IDLE;
            else if (step_q != lst || cont_i) begin
              state_q <= S_APPLY;
              step_q  <= nxt;
              ch_o    <= chan_a_i[nxt];
            end else state_q <= S_HOLD;
          end else begin
            smp_q   <= smp_q + 1'b1;
            state_q <= S_SOC;
            cnt_q   <= samp_ld;
          end
        end
        S_HOLD: if (!en_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_chan_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_o |=> $stable(ch_o));

  p_step_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (step_o <= $past(lst)));

  p_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !en_i) |=> (state_q == S_IDLE));
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  add_i,
  input  logic                  fire_i,
  input  logic [AVG_CODE_W-1:0] code_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic                  valid_o,
  output logic [DATA_W-1:0]     data_o
);
  localparam int ACC_W = DATA_W + 4;  // room for 16 full-scale words

  logic [ACC_W-1:0] acc_q, sum, avg;

  assign sum = acc_q + ACC_W'(data_i);
  assign avg = sum >> code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        acc_q  <= '0;
        data_o <= avg[DATA_W-1:0];
      end else if (add_i) begin
        acc_q <= sum;
      end
    end
  end

  p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int CHAN_W    = 4,
  parameter int OPEN_W    = 18,
  parameter int SAMP_W    = 8,
  parameter int DATA_W    = 12,
  localparam int STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 cont_i,
  input  logic [STEP_W-1:0]    last_step_i,
  input  logic                 cfg_we_i,
  input  logic [STEP_W-1:0]    cfg_step_i,
  input  logic [CHAN_W-1:0]    cfg_chan_i,
  input  logic [OPEN_W+1:0]    cfg_open_i,
  input  logic [SAMP_W+1:0]    cfg_samp_i,
  input  logic [AVG_REQ_W-1:0] cfg_avg_i,
  output logic [CHAN_W-1:0]    ch_o,
  output logic                 soc_o,
  input  logic                 adc_done_i,
  input  logic [DATA_W-1:0]    adc_data_i,
  output logic                 res_valid_o,
  output logic [DATA_W-1:0]    res_data_o,
  output logic [STEP_W-1:0]    res_step_o
);
  logic [CHAN_W-1:0]     chan_a [NUM_STEPS];
  logic [OPEN_W-1:0]     open_a [NUM_STEPS];
  logic [SAMP_W-1:0]     samp_a [NUM_STEPS];
  logic [AVG_CODE_W-1:0] code_a [NUM_STEPS];
  logic                  add, fire;
  logic [AVG_CODE_W-1:0] code;

  adc_step_cfg #(
    .NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W), .CHAN_W(CHAN_W),
    .OPEN_W(OPEN_W), .SAMP_W(SAMP_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_step_i), .chan_i(cfg_chan_i),
    .open_i(cfg_open_i), .samp_i(cfg_samp_i), .avg_i(cfg_avg_i),
    .chan_o(chan_a), .open_o(open_a), .samp_o(samp_a), .code_o(code_a)
  );

  adc_step_fsm #(
    .NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W), .CHAN_W(CHAN_W),
    .OPEN_W(OPEN_W), .SAMP_W(SAMP_W)
  ) u_fsm (
    .clk_i, .rst_ni, .en_i, .cont_i, .last_i(last_step_i),
    .chan_a_i(chan_a), .open_a_i(open_a), .samp_a_i(samp_a), .code_a_i(code_a),
    .done_i(adc_done_i), .ch_o, .soc_o, .add_o(add), .fire_o(fire),
    .code_o(code), .step_o(res_step_o)
  );

  adc_avg_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i, .rst_ni, .add_i(add), .fire_i(fire), .code_i(code),
    .data_i(adc_data_i), .valid_o(res_valid_o), .data_o(res_data_o)
  );
endmodule

// File: tb/tb_adc_step_seq.sv
`timescale 1ns/1ps
module tb_adc_step_seq;
  localparam int NS = 8, SW = 3, CW = 4, OW = 6, SPW = 8, DW = 12;
  localparam int OMAX = (1 << OW) - 1, SMAX = (1 << SPW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni = 1'b0, en_i = 1'b0, cont_i = 1'b0, cfg_we_i = 1'b0;
  logic [SW-1:0] last_step_i = '0, cfg_step_i = '0;
  logic [CW-1:0] cfg_chan_i = '0;
  logic [OW+1:0] cfg_open_i = '0;
  logic [SPW+1:0] cfg_samp_i = '0;
  logic [5:0]    cfg_avg_i = '0;
  logic [CW-1:0] ch_o;
  logic          soc_o, res_valid_o;
  logic          adc_done_i = 1'b0;
  logic [DW-1:0] adc_data_i = '0, res_data_o;
  logic [SW-1:0] res_step_o;

  adc_step_seq #(.NUM_STEPS(NS), .CHAN_W(CW), .OPEN_W(OW), .SAMP_W(SPW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni, .en_i, .cont_i, .last_step_i, .cfg_we_i, .cfg_step_i,
    .cfg_chan_i, .cfg_open_i, .cfg_samp_i, .cfg_avg_i, .ch_o, .soc_o,
    .adc_done_i, .adc_data_i, .res_valid_o, .res_data_o, .res_step_o
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected per-step settings (defaults per R8)
  int    exp_chan[NS], exp_open[NS], exp_samp[NS], exp_cnt[NS];
  string tag_o[NS], tag_s[NS];
  int    exp_cur = 0, exp_last = 0;
  int    soc_w = 0, lat = 0, gap_cnt = 0, conv_cnt = 0, conv_total = 0, sum = 0;
  int    n_res = 0, n_soc = 0;
  int    log_step[64];
  bit    gap_armed = 0, soc_prev = 0, val_prev = 0;

  initial begin
    for (int i = 0; i < NS; i++) begin
      exp_chan[i] = i; exp_open[i] = 0; exp_samp[i] = 0; exp_cnt[i] = 16;
      tag_o[i] = "R2"; tag_s[i] = "R3";
    end
  end

  // converter model and per-step checker
  always @(negedge clk) begin
    if (rst_ni) begin
      adc_done_i <= 1'b0;
      if (soc_o) begin
        if (!soc_prev) begin
          n_soc++;
          check(ch_o == CW'(exp_chan[exp_cur]), "R1 channel", int'(ch_o), exp_chan[exp_cur]);
          if (gap_armed) begin
            check(gap_cnt == exp_open[exp_cur], tag_o[exp_cur], gap_cnt, exp_open[exp_cur]);
            gap_armed = 0;
          end
        end
        soc_w++;
      end else begin
        if (soc_prev) begin
          check(soc_w == ((exp_samp[exp_cur] == 0) ? 1 : exp_samp[exp_cur]), tag_s[exp_cur],
                soc_w, (exp_samp[exp_cur] == 0) ? 1 : exp_samp[exp_cur]);
          soc_w = 0;
          lat = 3;
        end
        if (gap_armed) gap_cnt++;
      end
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          int v;
          v = (exp_chan[exp_cur] * 97 + conv_total * 13 + 5) % 4096;
          adc_done_i <= 1'b1;
          adc_data_i <= DW'(v);
          sum += v; conv_cnt++; conv_total++;
        end
      end
      if (res_valid_o) begin
        check(!val_prev, "R7 strobe width", 2, 1);
        check(res_step_o == SW'(exp_cur), "R7 step index", int'(res_step_o), exp_cur);
        check(conv_cnt == exp_cnt[exp_cur], "R4 conversions", conv_cnt, exp_cnt[exp_cur]);
        check(res_data_o == DW'(sum / exp_cnt[exp_cur]), "R5 average", int'(res_data_o),
              sum / exp_cnt[exp_cur]);
        if (n_res < 64) log_step[n_res] = int'(res_step_o);
        n_res++;
        sum = 0; conv_cnt = 0;
        exp_cur = (exp_cur == exp_last) ? 0 : exp_cur + 1;
        gap_cnt = 0; gap_armed = 1;
      end
      soc_prev = soc_o;
      val_prev = res_valid_o;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wcfg(int s, int c, int o, int sp, int a);
    cfg_we_i = 1'b1; cfg_step_i = SW'(s); cfg_chan_i = CW'(c);
    cfg_open_i = (OW+2)'(o); cfg_samp_i = (SPW+2)'(sp); cfg_avg_i = 6'(a);
    tick(1);
    cfg_we_i = 1'b0;
    exp_chan[s] = c;
    exp_open[s] = (o > OMAX) ? OMAX : o;
    exp_samp[s] = (sp > SMAX) ? SMAX : sp;
    tag_o[s] = (o > OMAX) ? "R6 open" : "R2";
    tag_s[s] = (sp > SMAX) ? "R6 sample" : "R3";
    exp_cnt[s] = (a >= 16) ? 16 : (a >= 8) ? 8 : (a >= 4) ? 4 : (a >= 2) ? 2 : 1;
  endtask

  task automatic start(int last, bit cont);
    exp_last = last; exp_cur = 0; gap_armed = 0; n_res = 0; n_soc = 0;
    last_step_i = SW'(last); cont_i = cont;
    en_i = 1'b1;
  endtask

  task automatic wait_res(int n, string req);
    int t = 0;
    while (n_res < n && t < 40000) begin tick(1); t++; end
    check(n_res >= n, req, n_res, n);
  endtask

  task automatic stop_idle();
    en_i = 1'b0;
    tick(40);
  endtask

  task automatic t_reset();
    check(soc_o == 1'b0, "R8 soc in reset", int'(soc_o), 0);
    check(res_valid_o == 1'b0, "R8 valid in reset", int'(res_valid_o), 0);
    rst_ni = 1'b1;
    tick(2);
    check(ch_o == '0, "R8 channel after reset", int'(ch_o), 0);
    check(soc_o == 1'b0, "R8 idle without enable", int'(soc_o), 0);
  endtask

  task automatic t_defaults();  // R8: 16 samples, channel 0 on step 0
    start(0, 1'b0);
    wait_res(1, "R8 default step completes");
    stop_idle();
  endtask

  task automatic t_timing();  // R2, R3, R6
    wcfg(0, 3, 5, 0, 1);
    wcfg(1, 9, 0, 4, 2);
    wcfg(2, 12, 200, 700, 1);
    wcfg(3, 4, 1, 1, 1);
    start(3, 1'b0);
    wait_res(4, "R2 timing pass completes");
    stop_idle();
  endtask

  task automatic t_avg();  // R4, R5, R1 order
    wcfg(0, 1, 0, 1, 2);
    wcfg(1, 2, 1, 0, 4);
    wcfg(2, 5, 0, 2, 8);
    wcfg(3, 6, 0, 0, 5);
    wcfg(4, 7, 2, 1, 40);
    wcfg(5, 8, 0, 0, 0);
    start(5, 1'b0);
    wait_res(6, "R4 averaging pass completes");
    for (int i = 0; i < 6; i++) check(log_step[i] == i, "R1 step order", log_step[i], i);
    stop_idle();
  endtask

  task automatic t_oneshot();  // R9
    int s0;
    start(1, 1'b0);
    wait_res(2, "R9 pass completes");
    s0 = n_soc;
    tick(300);
    check(n_soc == s0, "R9 no conversion after pass", n_soc, s0);
    check(n_res == 2, "R9 single pass", n_res, 2);
    en_i = 1'b0;
    tick(3);
    start(1, 1'b0);
    wait_res(2, "R9 restart after re-enable");
    check(log_step[0] == 0, "R9 restart at step 0", log_step[0], 0);
    stop_idle();
  endtask

  task automatic t_cont();  // R10, R11
    int s0;
    start(1, 1'b1);
    wait_res(4, "R10 continuous loop");
    en_i = 1'b0;  // step 0 conversion outstanding
    tick(100);
    s0 = n_soc;
    tick(300);
    check(n_res == 5, "R11 pending step still reported", n_res, 5);
    check(n_soc == s0, "R11 no conversion after stop", n_soc, s0);
    for (int i = 0; i < 5; i++) check(log_step[i] == (i % 2), "R10 wrap order", log_step[i], i % 2);
  endtask

  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    t_defaults();
    t_timing();
    t_avg();
    t_oneshot();
    t_cont();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule